// File: doc/BRIEF.md
# Display Frame Fetch Address Generator

This block turns a software-written display start register into the stream of RAM byte offsets that a bitmap display engine reads to paint one frame. The display is one bit per pixel. A frame is a fixed run of consecutive bytes in main RAM, and the register picks where that run begins. The register is 16 bits wide and is written over the bus as two bytes. The first frame byte sits at four times the register value. Every offset the block produces is counted from the bottom of main RAM, not from the start of the bus address map.

The display side pulses `frame_start` once per frame. The block then latches the base and presents the first offset. The consumer pulses `fetch_adv` each time it takes the offset on show, and the block answers with the next one. When the consumer takes the last byte of the frame (base + FRAME_BYTES - 1), the block raises `frame_end` for one cycle and drops `ofs_valid` until the next `frame_start`. The default span is 0x19000 bytes.

Top module: `frame_addr_gen`

## Requirements
- R1: Synchronous reset clears the start register to zero, drives `ofs_valid` and `frame_end` low and `ofs_out` to zero.
- R2: A write with `reg_wr_addr` = 0 loads `reg_wr_data` into bits 15:8 of the start register, and a write with `reg_wr_addr` = 1 loads bits 7:0. Each write leaves the other byte unchanged.
- R3: One cycle after `frame_start`, `ofs_valid` is high and `ofs_out` equals the start register value times four, zero-extended. This offset is relative to the base of RAM.
- R4: A `fetch_adv` while `ofs_valid` is high, on any byte but the last of the frame, makes `ofs_out` one larger in the next cycle, and `ofs_valid` stays high.
- R5: While `ofs_valid` is high and neither `fetch_adv` nor `frame_start` is asserted, `ofs_out` and `ofs_valid` hold.
- R6: A `fetch_adv` on the last byte (base + FRAME_BYTES - 1) raises `frame_end` for exactly one cycle in the next cycle and drops `ofs_valid` in that same cycle. A frame thus issues exactly FRAME_BYTES offsets.
- R7: Register writes during a frame do not change that frame's offsets. They take effect at the next `frame_start`. A write in the same cycle as `frame_start` is not seen until the following frame.
- R8: A `frame_start` while a frame is in progress restarts from a freshly latched base. It takes priority over a simultaneous `fetch_adv` and produces no `frame_end`.
- R9: While `ofs_valid` is low, `fetch_adv` is ignored: `ofs_out` holds, `ofs_valid` stays low and `frame_end` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Byte write strobe for the start register |
| reg_wr_addr | input | 1 | Byte select: 0 = high byte, 1 = low byte |
| reg_wr_data | input | 8 | Byte to write |
| frame_start | input | 1 | Latch base and begin a new frame |
| fetch_adv | input | 1 | Consumer took the presented offset |
| ofs_out | output | OFS_W (20) | RAM byte offset on show |
| ofs_valid | output | 1 | `ofs_out` belongs to a frame in progress |
| frame_end | output | 1 | One-cycle pulse after the last byte is taken |

## Verification
The bench builds the block with FRAME_BYTES = 12 and keeps the register at 16 bits and the offset at 20 bits. Every frame then ends within a dozen advances, so the bench can walk dozens of complete frames. These frames use many register values, including all-zero, all-one and single-byte patterns, and several gap patterns between advances. Each offset is checked against four times the register value plus the byte index. The short frame also makes the last-byte boundary, mid-frame restarts and mid-frame register writes cheap to hit many times.

// File: rtl/fag_pkg.sv
package fag_pkg;

  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_RUN  = 2'd1,
    WALK_DONE = 2'd2
  } walk_state_e;

endpackage

// File: rtl/fag_start_reg.sv
module fag_start_reg #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [REG_W-1:0]  reg_q
);
  import fag_pkg::*;

  localparam int unsigned NLANES = REG_W / LANE_W;

  // Big-endian lanes: lane 0 (lowest byte address) is the top byte.
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int unsigned HI = REG_W - 1 - g * LANE_W;
    always_ff @(posedge clk) begin
      if (rst) begin
        reg_q[HI -: LANE_W] <= '0;
      end else if (wr_en && (int'(wr_addr) == g)) begin
        reg_q[HI -: LANE_W] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/fag_base_scale.sv
module fag_base_scale #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned SHIFT = 2,
  parameter int unsigned OFS_W = 20
) (
  input  logic [REG_W-1:0] reg_val,
  output logic [OFS_W-1:0] base
);
  localparam int unsigned PAD = OFS_W - REG_W - SHIFT;

  assign base = {{PAD{1'b0}}, reg_val, {SHIFT{1'b0}}};

endmodule

// File: rtl/fag_walker.sv
module fag_walker #(
  parameter int unsigned OFS_W       = 20,
  parameter int unsigned FRAME_BYTES = 32'h19000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             adv,
  input  logic [OFS_W-1:0] base,
  output logic [OFS_W-1:0] ofs,
  output logic             valid,
  output logic             done
);
  import fag_pkg::*;

  localparam int unsigned CNT_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BYTES - 1);

  walk_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign valid   = (state_q == WALK_RUN);
  assign done    = (state_q == WALK_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WALK_IDLE;
      cnt_q   <= '0;
      ofs     <= '0;
    end else if (start) begin
      state_q <= WALK_RUN;
      cnt_q   <= '0;
      ofs     <= base;
    end else begin
      case (state_q)
        WALK_RUN: begin
          if (adv) begin
            if (at_last) begin
              state_q <= WALK_DONE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              ofs   <= ofs + 1'b1;
            end
          end
        end
        WALK_DONE: state_q <= WALK_IDLE;
        default:   state_q <= WALK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/frame_addr_gen.sv
module frame_addr_gen #(
  parameter int unsigned REG_W       = 16,
  parameter int unsigned SHIFT       = 2,
  parameter int unsigned OFS_W       = 20,
  parameter int unsigned FRAME_BYTES = 32'h19000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic             reg_wr_addr,
  input  logic [7:0]       reg_wr_data,
  input  logic             frame_start,
  input  logic             fetch_adv,
  output logic [OFS_W-1:0] ofs_out,
  output logic             ofs_valid,
  output logic             frame_end
);

  logic [REG_W-1:0] start_reg_q;
  logic [OFS_W-1:0] base_w;

  fag_start_reg #(.REG_W(REG_W), .ADDR_W(1)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .reg_q   (start_reg_q)
  );

  fag_base_scale #(.REG_W(REG_W), .SHIFT(SHIFT), .OFS_W(OFS_W)) u_scale (
    .reg_val (start_reg_q),
    .base    (base_w)
  );

  fag_walker #(.OFS_W(OFS_W), .FRAME_BYTES(FRAME_BYTES)) u_walk (
    .clk   (clk),
    .rst   (rst),
    .start (frame_start),
    .adv   (fetch_adv),
    .base  (base_w),
    .ofs   (ofs_out),
    .valid (ofs_valid),
    .done  (frame_end)
  );

endmodule

// File: rtl/fag_checker.sv
module fag_checker #(
  parameter int unsigned REG_W       = 16,
  parameter int unsigned SHIFT       = 2,
  parameter int unsigned OFS_W       = 20,
  parameter int unsigned FRAME_BYTES = 32'h19000
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             fetch_adv,
  input logic [OFS_W-1:0] ofs_out,
  input logic             ofs_valid,
  input logic             frame_end,
  input logic [REG_W-1:0] reg_val
);
  localparam int unsigned PAD = OFS_W - REG_W - SHIFT;

  // Count of advances taken since the last frame_start.
  logic [31:0] taken_q;
  always_ff @(posedge clk) begin
    if (rst || frame_start) taken_q <= '0;
    else if (ofs_valid && fetch_adv) taken_q <= taken_q + 1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> !ofs_valid && !frame_end && ofs_out == '0);

  a_r3_base_load: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> ofs_valid &&
      ofs_out == {{PAD{1'b0}}, $past(reg_val), {SHIFT{1'b0}}});

  a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
    ofs_valid && fetch_adv && !frame_start && taken_q != FRAME_BYTES - 1
    |=> ofs_valid && ofs_out == $past(ofs_out) + 1'b1);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    ofs_valid && !fetch_adv && !frame_start |=> ofs_valid && $stable(ofs_out));

  a_r6_end_count: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> !ofs_valid && taken_q == FRAME_BYTES);

  a_r6_end_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

  a_r9_idle_ignore: assert property (@(posedge clk) disable iff (rst)
    !ofs_valid && !frame_start |=> !ofs_valid && !frame_end && $stable(ofs_out));

endmodule

bind frame_addr_gen fag_checker #(
  .REG_W(REG_W), .SHIFT(SHIFT), .OFS_W(OFS_W), .FRAME_BYTES(FRAME_BYTES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .fetch_adv   (fetch_adv),
  .ofs_out     (ofs_out),
  .ofs_valid   (ofs_valid),
  .frame_end   (frame_end),
  .reg_val     (start_reg_q)
);

// File: tb/tb_frame_addr_gen.sv
`timescale 1ns/1ps
module tb_frame_addr_gen;
  localparam int FB    = 12;
  localparam int OFS_W = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_wr_en = 1'b0;
  logic             reg_wr_addr = 1'b0;
  logic [7:0]       reg_wr_data = '0;
  logic             frame_start = 1'b0;
  logic             fetch_adv = 1'b0;
  logic [OFS_W-1:0] ofs_out;
  logic             ofs_valid;
  logic             frame_end;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  frame_addr_gen #(.FRAME_BYTES(FB), .OFS_W(OFS_W)) dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .frame_start(frame_start), .fetch_adv(fetch_adv),
    .ofs_out(ofs_out), .ofs_valid(ofs_valid), .frame_end(frame_end)
  );

  task automatic chk(string req, logic ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic start_frame();
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
  endtask

  task automatic adv();
    fetch_adv = 1'b1;
    tick();
    fetch_adv = 1'b0;
  endtask

  // Full frame: base check, each offset, gaps, end pulse.
  task automatic run_frame(int val, int gmod);
    int base;
    base = val * 4;
    wr(1'b0, val[15:8]);
    wr(1'b1, val[7:0]);
    start_frame();
    chk("R3 base", ofs_valid && ofs_out == OFS_W'(base), int'(ofs_out), base);
    for (int k = 0; k < FB; k++) begin
      chk("R4 offset", ofs_valid && ofs_out == OFS_W'(base + k), int'(ofs_out), base + k);
      adv();
      if (k < FB - 1) begin
        chk("R6 no early end", !frame_end, int'(frame_end), 0);
        if (gmod != 0) begin
          for (int g = 0; g < (k % gmod); g++) begin
            tick();
            chk("R5 hold", ofs_valid && ofs_out == OFS_W'(base + k + 1),
                int'(ofs_out), base + k + 1);
          end
        end
      end
    end
    chk("R6 end pulse", frame_end && !ofs_valid, {frame_end, ofs_valid}, 2);
    tick();
    chk("R6 end one cycle", !frame_end && !ofs_valid, {frame_end, ofs_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    chk("R1 reset outputs", !ofs_valid && !frame_end && ofs_out == '0,
        int'(ofs_out), 0);
    // R9: advances ignored before any frame.
    adv(); tick();
    chk("R9 idle adv", !ofs_valid && !frame_end && ofs_out == '0, int'(ofs_out), 0);
    // R1: register reads as zero after reset.
    start_frame();
    chk("R1 reg zero", ofs_valid && ofs_out == '0, int'(ofs_out), 0);

    // R2: single-byte writes land in their own lane.
    wr(1'b1, 8'h05);
    start_frame();
    chk("R2 low lane", ofs_out == OFS_W'(32'h05 * 4), int'(ofs_out), 32'h14);
    wr(1'b0, 8'hA0);
    start_frame();
    chk("R2 high lane", ofs_out == OFS_W'(32'hA005 * 4), int'(ofs_out), 32'hA005 * 4);
    wr(1'b1, 8'h3C);
    start_frame();
    chk("R2 low keeps high", ofs_out == OFS_W'(32'hA03C * 4), int'(ofs_out), 32'hA03C * 4);

    // Sweep frames over many register values and gap patterns.
    run_frame(32'h0000, 0);
    run_frame(32'hFFFF, 0);
    run_frame(32'h00FF, 2);
    run_frame(32'hFF00, 3);
    run_frame(32'h8000, 0);
    run_frame(32'h1234, 2);
    for (int i = 0; i < 48; i++) run_frame(((i * 32'h0557) ^ (i << 11)) & 32'hFFFF, i % 4);

    // R9: advances after frame end are ignored.
    adv(); adv(); tick();
    chk("R9 after end", !ofs_valid && !frame_end, {ofs_valid, frame_end}, 0);

    // R7: mid-frame write does not disturb current frame.
    wr(1'b0, 8'h10); wr(1'b1, 8'h20);
    start_frame();
    adv(); adv(); adv();
    wr(1'b0, 8'h55); wr(1'b1, 8'h66);
    chk("R7 mid write ignored", ofs_out == OFS_W'(32'h1020 * 4 + 3), int'(ofs_out),
        32'h1020 * 4 + 3);
    for (int k = 3; k < FB; k++) adv();
    chk("R7 frame completes", frame_end, int'(frame_end), 1);
    start_frame();
    chk("R7 next frame new base", ofs_out == OFS_W'(32'h5566 * 4), int'(ofs_out),
        32'h5566 * 4);
    // R7: write in same cycle as frame_start uses the old value.
    reg_wr_en = 1'b1; reg_wr_addr = 1'b1; reg_wr_data = 8'h77; frame_start = 1'b1;
    tick();
    reg_wr_en = 1'b0; frame_start = 1'b0;
    chk("R7 same-cycle write", ofs_out == OFS_W'(32'h5566 * 4), int'(ofs_out),
        32'h5566 * 4);
    start_frame();
    chk("R7 same-cycle write next", ofs_out == OFS_W'(32'h5577 * 4), int'(ofs_out),
        32'h5577 * 4);

    // R8: restart mid-frame with concurrent advance, then near the last byte.
    adv(); adv();
    wr(1'b0, 8'h01); wr(1'b1, 8'h02);
    fetch_adv = 1'b1; frame_start = 1'b1;
    tick();
    fetch_adv = 1'b0; frame_start = 1'b0;
    chk("R8 restart base", ofs_valid && !frame_end && ofs_out == OFS_W'(32'h0102 * 4),
        int'(ofs_out), 32'h0102 * 4);
    for (int k = 0; k < FB - 1; k++) adv();
    fetch_adv = 1'b1; frame_start = 1'b1;
    tick();
    fetch_adv = 1'b0; frame_start = 1'b0;
    chk("R8 no end on restart", ofs_valid && !frame_end, {ofs_valid, frame_end}, 2);
    chk("R8 fresh count", ofs_out == OFS_W'(32'h0102 * 4), int'(ofs_out), 32'h0102 * 4);
    for (int k = 0; k < FB - 1; k++) adv();
    chk("R8 full frame after restart", !frame_end && ofs_valid, {ofs_valid, frame_end}, 2);
    adv();
    chk("R6 end after restart", frame_end, int'(frame_end), 1);

    // R1: reset mid-frame.
    start_frame(); adv();
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset mid-frame", !ofs_valid && !frame_end && ofs_out == '0, int'(ofs_out), 0);
    start_frame();
    chk("R1 reg cleared", ofs_out == '0, int'(ofs_out), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule